// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external 2048 x 8 asynchronous static RAM. The host asks for one byte at a time with a request/ready handshake. The controller turns each request into a sequence of active-low chip-select, output-gate and write-strobe levels on the RAM. It holds each level for a number of clock cycles that it derives at elaboration time from nanosecond figures and the clock period.

A write always starts with the RAM's output gate high. The controller waits out the RAM's output-disable time before it drives the data bus, so the two never fight. The RAM stores the byte on the rising edge of the write strobe. A read keeps the select and gate low until the access time has passed. The controller registers the byte from the bus on the last cycle of the read, before it lets the select go.

After reset the controller waits a power-up interval before it raises ready. While it is idle, a retention request parks it with the RAM deselected until a wake pulse arrives. The wake pulse starts the power-up interval again. The shared data bus appears as three separate signals, ram_dq_out, ram_dq_oe and ram_dq_in. The tri-state pad that joins them sits outside this block.

Top module: `asram_ctrl`

## Requirements
- R1: During reset and for ceil(55 ns / clock period) cycles after reset is released (3 cycles at 20 ns), ram_ce_n, ram_oe_n and ram_we_n are high, ram_dq_oe is low and ready is low. After that, ready is high.
- R2: An accepted read (req_we = 0) holds ram_ce_n and ram_oe_n low and ram_we_n high for the largest of ceil(70 ns), ceil(35 ns) and ceil(70 ns read cycle) in clock cycles (4 at 20 ns). ram_addr equals req_addr throughout. rdata holds the value seen on ram_dq_in in the last of those cycles.
- R3: During an accepted write (req_we = 1), ram_oe_n stays high for as long as ram_ce_n is low. ram_we_n falls only after max(ceil(10 ns), ceil(30 ns)) cycles with ram_ce_n low (2 at 20 ns). ram_dq_oe stays low during that setup.
- R4: ram_we_n stays low for max(ceil(40 ns), ceil(30 ns)) cycles (2 at 20 ns). During that time ram_dq_oe is high and ram_dq_out equals req_wdata without change. ram_dq_oe is still high in the first cycle after ram_we_n rises.
- R5: ram_we_n is low only while ram_ce_n is low. ram_addr does not change while ram_we_n is low or in the cycle it rises. ram_ce_n stays low for at least ceil(70 ns) cycles per write.
- R6: ram_dq_oe is never high while ram_oe_n is low.
- R7: Each accepted request gives exactly one done pulse of one cycle, in the cycle after ram_ce_n is released. ready is high only when the controller is idle. req and ret_req are ignored while ready is low.
- R8: ret_req is acted on only when ready is high and req is low; when both are high, the request is served and ret_req is dropped. In retention, ram_ce_n and ram_oe_n stay high and ready stays low, and req is ignored.
- R9: A wake pulse in retention restarts the power-up wait. ready returns 1 + ceil(55 ns) clock edges after the edge that samples wake, and ram_ce_n stays high meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Host access request, taken when ready is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Word address |
| req_wdata | input | 8 | Byte to write |
| ret_req | input | 1 | Enter low-power retention (idle only) |
| wake | input | 1 | Leave retention and restart the power-up wait |
| ready | output | 1 | Idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte captured by the last read |
| ram_addr | output | 11 | RAM address lines |
| ram_ce_n | output | 1 | RAM chip select, active low |
| ram_oe_n | output | 1 | RAM output gate, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_dq_out | output | 8 | Byte to drive onto the shared data bus |
| ram_dq_oe | output | 1 | Enable for the controller's bus driver |
| ram_dq_in | input | 8 | Value currently on the shared data bus |

## Verification
The bench's RAM model returns a marker byte until the access time has run. A controller that latched read data one cycle early would therefore return the marker instead of the stored byte. The bench measures the setup, strobe and hold cycles of each write and flags any cycle where the driver is on while the RAM's output gate is low. A design that raised the driver together with the select, or dropped it at the strobe's rising edge, fails these checks. Requests and retention pulses are injected mid-access, and a request is raised during retention. A design that re-armed on them would start a second access or leave ready low.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP = 3'd0,
    ST_IDLE  = 3'd1,
    ST_RET   = 3'd2,
    ST_RD    = 3'd3,
    ST_WSET  = 3'd4,
    ST_WPUL  = 3'd5,
    ST_WHLD  = 3'd6,
    ST_DONE  = 3'd7
  } asram_state_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } asram_strobe_t;

  localparam asram_strobe_t STROBE_PARKED = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

  // Whole clock cycles covering a nanosecond interval, never less than one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Pin levels for each state; the driver is enabled only between the
  // output-disable wait and the cycle after the strobe rises.
  function automatic asram_strobe_t strobe_decode(input asram_state_e st);
    asram_strobe_t s;
    s = STROBE_PARKED;
    case (st)
      ST_RD:   begin s.ce_n = 1'b0; s.oe_n = 1'b0; end
      ST_WSET: begin s.ce_n = 1'b0; end
      ST_WPUL: begin s.ce_n = 1'b0; s.we_n = 1'b0; s.dq_oe = 1'b1; end
      ST_WHLD: begin s.ce_n = 1'b0; s.dq_oe = 1'b1; end
      default: s = STROBE_PARKED;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/asram_wait_timer.sv
module asram_wait_timer #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_CNT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cycles,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(RST_CNT);
    end else if (load) begin
      cnt_q <= load_cycles - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned PU_CYC   = 3,
  parameter int unsigned RD_CYC   = 4,
  parameter int unsigned WSET_CYC = 2,
  parameter int unsigned WPUL_CYC = 2,
  parameter int unsigned WHLD_CYC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic          ret_req,
  input  logic          wake,
  output asram_state_e  state,
  output asram_strobe_t strobe,
  output logic          accept,
  output logic          rd_capture
);

  asram_state_e     state_q, state_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_cycles;
  logic             tmr_last;
  asram_strobe_t    strobe_q;

  asram_wait_timer #(
    .CNT_W  (CNT_W),
    .RST_CNT(PU_CYC - 1)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (tmr_load),
    .load_cycles(tmr_cycles),
    .last       (tmr_last)
  );

  always_comb begin
    state_d    = state_q;
    tmr_load   = 1'b0;
    tmr_cycles = '0;
    case (state_q)
      ST_PWRUP: if (tmr_last) state_d = ST_IDLE;
      ST_IDLE: begin
        if (req) begin
          tmr_load = 1'b1;
          if (req_we) begin
            state_d    = ST_WSET;
            tmr_cycles = CNT_W'(WSET_CYC);
          end else begin
            state_d    = ST_RD;
            tmr_cycles = CNT_W'(RD_CYC);
          end
        end else if (ret_req) begin
          state_d = ST_RET;
        end
      end
      ST_RET: begin
        if (wake) begin
          state_d    = ST_PWRUP;
          tmr_load   = 1'b1;
          tmr_cycles = CNT_W'(PU_CYC);
        end
      end
      ST_RD: if (tmr_last) state_d = ST_DONE;
      ST_WSET: begin
        if (tmr_last) begin
          state_d    = ST_WPUL;
          tmr_load   = 1'b1;
          tmr_cycles = CNT_W'(WPUL_CYC);
        end
      end
      ST_WPUL: begin
        if (tmr_last) begin
          state_d    = ST_WHLD;
          tmr_load   = 1'b1;
          tmr_cycles = CNT_W'(WHLD_CYC);
        end
      end
      ST_WHLD: if (tmr_last) state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Strobes are registered from the next state so the pins come straight from flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_PWRUP;
      strobe_q <= STROBE_PARKED;
    end else begin
      state_q  <= state_d;
      strobe_q <= strobe_decode(state_d);
    end
  end

  assign state      = state_q;
  assign strobe     = strobe_q;
  assign accept     = (state_q == ST_IDLE) && req;
  assign rd_capture = (state_q == ST_RD) && tmr_last;

endmodule

// File: rtl/asram_dq_path.sv
module asram_dq_path #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              rd_capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] ram_dq_in,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic [DATA_W-1:0] rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_capture) begin
      rdata_q <= ram_dq_in;
    end
  end

  assign ram_addr   = addr_q;
  assign ram_dq_out = wdata_q;
  assign rdata      = rdata_q;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned CLK_NS    = 20,
  parameter int unsigned T_AA_NS   = 70,
  parameter int unsigned T_ACE_NS  = 70,
  parameter int unsigned T_AOE_NS  = 35,
  parameter int unsigned T_RC_NS   = 70,
  parameter int unsigned T_AS_NS   = 10,
  parameter int unsigned T_OHZ_NS  = 30,
  parameter int unsigned T_WP_NS   = 40,
  parameter int unsigned T_DS_NS   = 30,
  parameter int unsigned T_AH_NS   = 10,
  parameter int unsigned T_WC_NS   = 70,
  parameter int unsigned T_PU_NS   = 55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ret_req,
  input  logic              wake,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in
);

  localparam int unsigned PU_CYC   = ns_to_cyc(T_PU_NS, CLK_NS);
  localparam int unsigned RD_CYC   = max_u(max_u(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_ACE_NS, CLK_NS)),
                                           max_u(ns_to_cyc(T_AOE_NS, CLK_NS), ns_to_cyc(T_RC_NS, CLK_NS)));
  localparam int unsigned WSET_CYC = max_u(ns_to_cyc(T_AS_NS, CLK_NS), ns_to_cyc(T_OHZ_NS, CLK_NS));
  localparam int unsigned WPUL_CYC = max_u(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS));
  localparam int unsigned WC_CYC   = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int unsigned WREST    = (WC_CYC > WSET_CYC + WPUL_CYC) ? (WC_CYC - WSET_CYC - WPUL_CYC) : 1;
  localparam int unsigned WHLD_CYC = max_u(ns_to_cyc(T_AH_NS, CLK_NS), WREST);

  asram_state_e  state;
  asram_strobe_t strobe;
  logic          accept;
  logic          rd_capture;
  logic          ret_active;

  asram_seq #(
    .CNT_W   (CNT_W),
    .PU_CYC  (PU_CYC),
    .RD_CYC  (RD_CYC),
    .WSET_CYC(WSET_CYC),
    .WPUL_CYC(WPUL_CYC),
    .WHLD_CYC(WHLD_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .req_we    (req_we),
    .ret_req   (ret_req),
    .wake      (wake),
    .state     (state),
    .strobe    (strobe),
    .accept    (accept),
    .rd_capture(rd_capture)
  );

  asram_dq_path #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .rd_capture(rd_capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ram_dq_in (ram_dq_in),
    .ram_addr  (ram_addr),
    .ram_dq_out(ram_dq_out),
    .rdata     (rdata)
  );

  assign ready      = (state == ST_IDLE);
  assign done       = (state == ST_DONE);
  assign ret_active = (state == ST_RET);
  assign ram_ce_n   = strobe.ce_n;
  assign ram_oe_n   = strobe.oe_n;
  assign ram_we_n   = strobe.we_n;
  assign ram_dq_oe  = strobe.dq_oe;

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned WSET_CYC = 2,
  parameter int unsigned WPUL_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ram_ce_n,
  input logic              ram_oe_n,
  input logic              ram_we_n,
  input logic              ram_dq_oe,
  input logic [DATA_W-1:0] ram_dq_out,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              done,
  input logic              ready,
  input logic              ret_active
);

  logic [7:0] setup_cnt;
  logic [7:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_cnt <= '0;
      low_cnt   <= '0;
    end else begin
      if (ram_ce_n) setup_cnt <= '0;
      else if (ram_we_n && setup_cnt != 8'hFF) setup_cnt <= setup_cnt + 1'b1;
      if (!ram_we_n && low_cnt != 8'hFF) low_cnt <= low_cnt + 1'b1;
      else if (ram_we_n) low_cnt <= '0;
    end
  end

  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !ram_we_n |-> ram_oe_n); // R3
  AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n) $fell(ram_we_n) |-> (setup_cnt >= WSET_CYC)); // R3
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $rose(ram_we_n) |-> (low_cnt >= WPUL_CYC)); // R4
  AST_DQ_STEADY: assert property (@(posedge clk) disable iff (!rst_n) (ram_dq_oe && $past(ram_dq_oe)) |-> $stable(ram_dq_out)); // R4
  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n) !ram_we_n |-> !ram_ce_n); // R5
  AST_ADDR_HELD_WE: assert property (@(posedge clk) disable iff (!rst_n) !ram_we_n |-> $stable(ram_addr)); // R5
  AST_ADDR_HELD_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(ram_we_n) |-> $stable(ram_addr)); // R5
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n) ram_dq_oe |-> ram_oe_n); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_RET_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) ret_active |-> (ram_ce_n && ram_oe_n && !ready)); // R8

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .WSET_CYC(WSET_CYC),
  .WPUL_CYC(WPUL_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ram_ce_n  (ram_ce_n),
  .ram_oe_n  (ram_oe_n),
  .ram_we_n  (ram_we_n),
  .ram_dq_oe (ram_dq_oe),
  .ram_dq_out(ram_dq_out),
  .ram_addr  (ram_addr),
  .done      (done),
  .ready     (ready),
  .ret_active(ret_active)
);

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;

  localparam int CLK_NS = 20;

  // Cycle count for an interval, by repeated subtraction.
  function automatic int span(input int ns);
    int n = 0;
    int left = ns;
    while (left > 0) begin left -= CLK_NS; n++; end
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int bigger(input int a, input int b);
    return (a >= b) ? a : b;
  endfunction

  localparam int PU_EXP = 3;  // 55 ns
  localparam int RD_EXP = 4;  // 70 ns access
  int setup_exp, wp_exp, wc_exp;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_we = 1'b0, ret_req = 1'b0, wake = 1'b0;
  logic [10:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ready, done;
  logic [7:0]  rdata, ram_dq_out, ram_dq_in;
  logic [10:0] ram_addr;
  logic        ram_ce_n, ram_oe_n, ram_we_n, ram_dq_oe;

  int checks = 0, errors = 0, fight = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  asram_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .ret_req(ret_req), .wake(wake), .ready(ready), .done(done),
    .rdata(rdata), .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n),
    .ram_we_n(ram_we_n), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  // RAM model: marker byte until the access interval has run.
  logic [7:0] ram [0:2047];
  logic [7:0] exp_mem [0:2047];
  int rd_run = 0;
  always @(posedge clk) rd_run <= (!ram_ce_n && !ram_oe_n) ? rd_run + 1 : 0;
  always @(posedge ram_we_n) if (!ram_ce_n && ram_dq_oe) ram[ram_addr] <= ram_dq_out;
  assign ram_dq_in = (!ram_ce_n && !ram_oe_n && rd_run >= RD_EXP - 1) ? ram[ram_addr] : 8'hA5;

  always @(negedge clk) if (ram_dq_oe && !ram_ce_n && !ram_oe_n) fight++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic idle_hold(input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!ready || !ram_ce_n) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic t_reset();
    int n = 0;
    repeat (3) @(negedge clk);
    chk(ram_ce_n && ram_oe_n && ram_we_n && !ram_dq_oe && !ready, "R1 pins parked in reset", ready, 0);
    rst_n = 1'b1;
    while (!ready && n < 20) begin @(posedge clk); n++; @(negedge clk); end
    chk(n == PU_EXP, "R1 power-up wait", n, PU_EXP);
  endtask

  task automatic t_write(input logic [10:0] a, input logic [7:0] d, input bit inject);
    int setup = 0, wl = 0, celow = 0, oe_bad = 0, a_bad = 0, d_bad = 0, early = 0, hold_oe = -1, it = 0;
    bit seen = 0;
    @(negedge clk);
    req = 1; req_we = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 0;
    while (it < 40) begin
      if (inject && it == 1) begin req = 1; req_we = 0; req_addr = ~a; ret_req = 1; end
      if (inject && it == 2) begin req = 0; ret_req = 0; end
      if (!ram_ce_n) begin
        celow++;
        if (!ram_oe_n) oe_bad++;
        if (ram_addr != a) a_bad++;
      end
      if (!ram_ce_n && ram_we_n && !seen) begin setup++; if (ram_dq_oe) early++; end
      if (!ram_we_n) begin seen = 1; wl++; if (!ram_dq_oe || ram_dq_out != d) d_bad++; end
      if (seen && ram_we_n && !ram_ce_n && hold_oe < 0) hold_oe = ram_dq_oe;
      if (done) break;
      it++;
      @(negedge clk);
    end
    req = 0; ret_req = 0;
    exp_mem[a] = d;
    chk(setup == setup_exp, "R3 setup cycles before strobe", setup, setup_exp);
    chk(early == 0 && oe_bad == 0, "R3 gate high and driver off in setup", early + oe_bad, 0);
    chk(wl == wp_exp, "R4 strobe width", wl, wp_exp);
    chk(d_bad == 0, "R4 data driven and steady", d_bad, 0);
    chk(hold_oe == 1, "R4 driver held after strobe rise", hold_oe, 1);
    chk(a_bad == 0 && celow >= wc_exp, "R5 address held and write cycle length", celow, wc_exp);
    chk(done && ram_ce_n, "R7 done after select release", done, 1);
    @(negedge clk);
    chk(!done && ready, "R7 done is one cycle", done, 0);
  endtask

  task automatic t_read(input logic [10:0] a, input bit with_ret, input bit inject);
    int rc = 0, a_bad = 0, it = 0;
    @(negedge clk);
    req = 1; req_we = 0; req_addr = a; ret_req = with_ret;
    @(negedge clk);
    req = 0; ret_req = 0;
    while (it < 40) begin
      if (inject && it == 1) begin req = 1; req_we = 1; ret_req = 1; end
      if (inject && it == 2) begin req = 0; ret_req = 0; end
      if (!ram_ce_n && !ram_oe_n && ram_we_n) begin rc++; if (ram_addr != a) a_bad++; end
      if (done) break;
      it++;
      @(negedge clk);
    end
    req = 0; ret_req = 0;
    chk(rc == RD_EXP && a_bad == 0, "R2 read strobe cycles", rc, RD_EXP);
    chk(rdata == exp_mem[a], "R2 read data", rdata, exp_mem[a]);
    @(negedge clk);
    chk(!done && ready, "R7 single done on read", done, 0);
  endtask

  task automatic t_retention();
    int bad = 0, n = 0;
    @(negedge clk);
    ret_req = 1;
    @(negedge clk);
    ret_req = 0;
    for (int i = 0; i < 8; i++) begin
      if (i == 3) begin req = 1; req_we = 0; req_addr = 11'h010; end
      if (i == 4) req = 0;
      if (!ram_ce_n || !ram_oe_n || ready) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R8 deselected in retention, request ignored", bad, 0);
    wake = 1;
    bad = 0;
    while (!ready && n < 20) begin
      @(posedge clk); n++; @(negedge clk); wake = 0;
      if (!ram_ce_n) bad++;
    end
    chk(n == PU_EXP + 1 && bad == 0, "R9 wake restarts power-up wait", n, PU_EXP + 1);
  endtask

  initial begin
    setup_exp = bigger(span(10), span(30));
    wp_exp    = bigger(span(40), span(30));
    wc_exp    = span(70);
    for (int i = 0; i < 2048; i++) exp_mem[i] = 8'h00;
    t_reset();
    t_write(11'h123, 8'h5C, 0);
    t_read(11'h123, 0, 0);
    t_write(11'h7FF, 8'hFF, 0);
    t_write(11'h001, 8'h00, 1);
    idle_hold(6, "R7 request during write ignored");
    t_read(11'h7FF, 0, 1);
    idle_hold(6, "R8 retention request during read ignored");
    t_read(11'h001, 1, 0);
    idle_hold(4, "R8 request beats retention");
    t_retention();
    t_write(11'h400, 8'h3A, 0);
    t_read(11'h400, 0, 0);
    chk(fight == 0, "R6 no bus contention", fight, 0);
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    report();
  end

endmodule